// File: doc/BRIEF.md
# Reset Domain Isolation Sequencer

This block resets one section of a chip while a neighbouring section keeps running. The source section's registers feed a receiving section that never enters reset. If the source flops were reset asynchronously while the receiving flops were still capturing, the receiver could go metastable or capture garbage. The sequencer prevents this by running a fixed ordering for every reset request. It first isolates the receiver, then drives the source reset, then releases that reset on a clock edge, waits for a settle period, and only then removes isolation.

The isolation signal drives the capture enable of the receiving registers. One such receiving register is included, and it holds its contents for as long as isolation is active. The isolation length, reset length and settle length are parameters. A request that arrives while a sequence is running is remembered. It starts a fresh sequence as soon as the running one ends, with no idle cycle between the two sequences. Any number of extra requests during one sequence collapse into that single follow-up sequence.

Top module: `rst_iso_seq`

## Requirements
- R1: While the active-low controller reset `rst_n` is low, `iso_en`, `src_rst` and `busy` are 0 and `rx_data` is 0. An assertion of `rst_n` in the middle of a sequence forces all of them to 0 immediately.
- R2: A request sampled high while idle raises `iso_en` and `busy` at that same edge. `src_rst` then stays low for ISO_CYCLES cycles (at least 1) of isolation before it rises.
- R3: `src_rst` is high for exactly RESET_CYCLES consecutive cycles (at least 2) per sequence, and it is high only while `iso_en` is high.
- R4: `src_rst` comes from a flop and falls on a clock edge. After it falls, `iso_en` stays high for 1 + SETTLE_CYCLES further cycles with `src_rst` low.
- R5: A sequence always runs in the order isolate, reset, release, settle. `iso_en` never falls while `src_rst` is high or in the cycle right after `src_rst` was high.
- R6: At each clock edge where `iso_en` is low, `rx_data` loads `src_data`. At each edge where `iso_en` is high, `rx_data` keeps its value whatever `src_data` does.
- R7: A request seen at any edge while busy, including the edge that ends the last settle cycle, starts the next sequence as soon as the current one ends. The next isolation phase follows the last settle cycle directly, with `iso_en` and `busy` staying high.
- R8: Several requests seen during one sequence produce exactly one follow-up sequence.
- R9: `busy` is high from the first isolation cycle through the last settle cycle and low in idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset of the sequencer |
| req | input | 1 | Request to reset the source section |
| src_data | input | DATA_W | Data from the source section into the receiving register |
| iso_en | output | 1 | Isolation enable; holds the receiving registers |
| src_rst | output | 1 | Active-high reset for the source section |
| busy | output | 1 | High while a sequence is running |
| rx_data | output | DATA_W | Contents of the isolated receiving register |

## Verification
The bench chains sequences back to back by placing requests inside the isolation phase, inside the reset phase and on the very last settle edge. A design that drops a late request would return to idle there, and one that inserts an idle cycle would show a gap in `busy`. Duplicate requests within one sequence are sent to catch a design that counts requests instead of latching them, which would run a third sequence. Source data changes on every cycle of every sequence, so a receiving register that captures during isolation shows a different value from the one taken on the edge before isolation rose. A controller reset in the middle of the reset phase checks that the source reset and isolation both drop at once.

// File: rtl/rsq_pkg.sv
package rsq_pkg;

   typedef enum logic [2:0] {
      RSQ_IDLE    = 3'd0,
      RSQ_ISOLATE = 3'd1,
      RSQ_RESET   = 3'd2,
      RSQ_RELEASE = 3'd3,
      RSQ_SETTLE  = 3'd4
   } rsq_state_e;

   function automatic int rsq_max3(input int a, input int b, input int c);
      int m;
      m = (a > b) ? a : b;
      return (m > c) ? m : c;
   endfunction

endpackage

// File: rtl/rsq_timer.sv
module rsq_timer #(
   parameter int CNT_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] load_val,
   output logic             expired
);

   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
      end else if (load) begin
         cnt_q <= load_val;
      end else if (cnt_q != '0) begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign expired = (cnt_q == '0);

endmodule

// File: rtl/rsq_ctrl.sv
module rsq_ctrl
   import rsq_pkg::*;
#(
   parameter int ISO_CYCLES    = 1,
   parameter int RESET_CYCLES  = 2,
   parameter int SETTLE_CYCLES = 1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       req,
   output rsq_state_e state_d
);

   localparam int MAX_LEN = rsq_max3(ISO_CYCLES, RESET_CYCLES, SETTLE_CYCLES);
   localparam int CNT_W   = (MAX_LEN > 2) ? $clog2(MAX_LEN) : 1;
   localparam logic [CNT_W-1:0] ISO_LD = CNT_W'(ISO_CYCLES - 1);
   localparam logic [CNT_W-1:0] RST_LD = CNT_W'(RESET_CYCLES - 1);
   localparam logic [CNT_W-1:0] SET_LD = CNT_W'(SETTLE_CYCLES - 1);

   rsq_state_e       state_q;
   logic             pend_q;
   logic             pend_d;
   logic             seq_end;
   logic             tmr_load;
   logic [CNT_W-1:0] tmr_val;
   logic             tmr_expired;

   rsq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (tmr_load),
      .load_val (tmr_val),
      .expired  (tmr_expired)
   );

   always_comb begin
      state_d  = state_q;
      tmr_load = 1'b0;
      tmr_val  = '0;
      seq_end  = 1'b0;
      case (state_q)
         RSQ_IDLE: begin
            if (req) begin
               state_d  = RSQ_ISOLATE;
               tmr_load = 1'b1;
               tmr_val  = ISO_LD;
            end
         end
         RSQ_ISOLATE: begin
            if (tmr_expired) begin
               state_d  = RSQ_RESET;
               tmr_load = 1'b1;
               tmr_val  = RST_LD;
            end
         end
         RSQ_RESET: begin
            if (tmr_expired) begin
               state_d = RSQ_RELEASE;
            end
         end
         RSQ_RELEASE: begin
            state_d  = RSQ_SETTLE;
            tmr_load = 1'b1;
            tmr_val  = SET_LD;
         end
         RSQ_SETTLE: begin
            if (tmr_expired) begin
               seq_end = 1'b1;
               if (req || pend_q) begin
                  state_d  = RSQ_ISOLATE;
                  tmr_load = 1'b1;
                  tmr_val  = ISO_LD;
               end else begin
                  state_d = RSQ_IDLE;
               end
            end
         end
         default: state_d = RSQ_IDLE;
      endcase
   end

   assign pend_d = seq_end ? 1'b0 : (pend_q | (req & (state_q != RSQ_IDLE)));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= RSQ_IDLE;
         pend_q  <= 1'b0;
      end else begin
         state_q <= state_d;
         pend_q  <= pend_d;
      end
   end

endmodule

// File: rtl/rsq_out_stage.sv
module rsq_out_stage
   import rsq_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  rsq_state_e state_d,
   output logic       iso_q,
   output logic       rst_q,
   output logic       busy_q
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         iso_q  <= 1'b0;
         rst_q  <= 1'b0;
         busy_q <= 1'b0;
      end else begin
         iso_q  <= (state_d != RSQ_IDLE);
         rst_q  <= (state_d == RSQ_RESET);
         busy_q <= (state_d != RSQ_IDLE);
      end
   end

endmodule

// File: rtl/rsq_hold_reg.sv
module rsq_hold_reg #(
   parameter int DATA_W     = 8,
   parameter bit RESETTABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hold,
   input  logic [DATA_W-1:0] d,
   output logic [DATA_W-1:0] q
);

   generate
      if (RESETTABLE) begin : g_rst
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               q <= '0;
            end else if (!hold) begin
               q <= d;
            end
         end
      end else begin : g_norst
         logic unused_rst;
         assign unused_rst = rst_n;
         always_ff @(posedge clk) begin
            if (!hold) begin
               q <= d;
            end
         end
      end
   endgenerate

endmodule

// File: rtl/rst_iso_seq.sv
module rst_iso_seq
   import rsq_pkg::*;
#(
   parameter int DATA_W        = 8,
   parameter int ISO_CYCLES    = 1,
   parameter int RESET_CYCLES  = 2,
   parameter int SETTLE_CYCLES = 1,
   parameter bit RX_RESETTABLE = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req,
   input  logic [DATA_W-1:0] src_data,
   output logic              iso_en,
   output logic              src_rst,
   output logic              busy,
   output logic [DATA_W-1:0] rx_data
);

   generate
      if (DATA_W < 1) begin : g_bad_w
         $error("rst_iso_seq: DATA_W must be at least 1");
      end
      if (ISO_CYCLES < 1) begin : g_bad_iso
         $error("rst_iso_seq: ISO_CYCLES must be at least 1");
      end
      if (RESET_CYCLES < 2) begin : g_bad_rst
         $error("rst_iso_seq: RESET_CYCLES must be at least 2");
      end
      if (SETTLE_CYCLES < 1) begin : g_bad_set
         $error("rst_iso_seq: SETTLE_CYCLES must be at least 1");
      end
   endgenerate

   rsq_state_e next_state;

   rsq_ctrl #(
      .ISO_CYCLES    (ISO_CYCLES),
      .RESET_CYCLES  (RESET_CYCLES),
      .SETTLE_CYCLES (SETTLE_CYCLES)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .req     (req),
      .state_d (next_state)
   );

   rsq_out_stage u_out (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_d (next_state),
      .iso_q   (iso_en),
      .rst_q   (src_rst),
      .busy_q  (busy)
   );

   rsq_hold_reg #(
      .DATA_W     (DATA_W),
      .RESETTABLE (RX_RESETTABLE)
   ) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .hold  (iso_en),
      .d     (src_data),
      .q     (rx_data)
   );

endmodule

// File: rtl/rsq_checker.sv
module rsq_checker #(
   parameter int DATA_W       = 8,
   parameter int RESET_CYCLES = 2
) (
   input logic              clk,
   input logic              rst_n,
   input logic              iso_en,
   input logic              src_rst,
   input logic              busy,
   input logic [DATA_W-1:0] rx_data
);

   int unsigned rst_run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rst_run <= 0;
      end else if (src_rst) begin
         rst_run <= rst_run + 1;
      end else begin
         rst_run <= 0;
      end
   end

   assert_iso_covers_rst_R3: assert property (@(posedge clk) disable iff (!rst_n)
      src_rst |-> iso_en);

   assert_iso_leads_rst_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(src_rst) |-> $past(iso_en));

   assert_rst_length_R3: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(src_rst) |-> (rst_run == RESET_CYCLES));

   assert_iso_drop_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(iso_en) |-> (!src_rst && !$past(src_rst)));

   assert_rx_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $past(iso_en) |-> $stable(rx_data));

   assert_busy_covers_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (iso_en || src_rst) |-> busy);

endmodule

bind rst_iso_seq rsq_checker #(
   .DATA_W       (DATA_W),
   .RESET_CYCLES (RESET_CYCLES)
) u_rsq_checker (
   .clk     (clk),
   .rst_n   (rst_n),
   .iso_en  (iso_en),
   .src_rst (src_rst),
   .busy    (busy),
   .rx_data (rx_data)
);

// File: tb/rst_iso_seq_test.sv
module rst_iso_seq_test;

   localparam int DW  = 8;
   localparam int ISO = 2;
   localparam int RST = 3;
   localparam int SET = 2;
   localparam int L   = ISO + RST + 1 + SET;

   typedef struct {
      int          at;
      logic        busy;
      logic        iso;
      logic        rst;
      logic [DW-1:0] rx;
      string       tag;
   } item_t;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req = 1'b0;
   logic [DW-1:0] src_data = '0;
   logic          iso_en;
   logic          src_rst;
   logic          busy;
   logic [DW-1:0] rx_data;

   item_t         q[$];
   int            n_cmp = 0;
   int            n_bad = 0;
   int            cyc = 0;
   logic          prev_iso = 1'b0;
   logic [DW-1:0] held = '0;
   bit            done = 1'b0;

   always #2 clk = ~clk;

   rst_iso_seq #(
      .DATA_W        (DW),
      .ISO_CYCLES    (ISO),
      .RESET_CYCLES  (RST),
      .SETTLE_CYCLES (SET),
      .RX_RESETTABLE (1'b1)
   ) uut (
      .clk      (clk),
      .rst_n    (rst_n),
      .req      (req),
      .src_data (src_data),
      .iso_en   (iso_en),
      .src_rst  (src_rst),
      .busy     (busy),
      .rx_data  (rx_data)
   );

   always @(posedge clk) cyc <= cyc + 1;

   // monitor: pops the items due in this cycle and compares them
   always @(negedge clk) begin
      item_t it;
      while (q.size() > 0 && q[0].at <= cyc) begin
         it = q.pop_front();
         n_cmp++;
         if (it.at < cyc) begin
            n_bad++;
            $display("FAIL %s: item for cycle %0d missed, now %0d", it.tag, it.at, cyc);
         end else if (busy !== it.busy || iso_en !== it.iso ||
                      src_rst !== it.rst || rx_data !== it.rx) begin
            n_bad++;
            $display("FAIL %s cycle %0d: busy/iso/rst/rx got %b%b%b/%h expected %b%b%b/%h",
                     it.tag, cyc, busy, iso_en, src_rst, rx_data,
                     it.busy, it.iso, it.rst, it.rx);
         end
      end
   end

   task automatic direct_chk(input bit ok, input string tag, input string got, input string exp);
      n_cmp++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s: got %s expected %s", tag, got, exp);
      end
   endtask

   // driver: drives one cycle of inputs and pushes the outputs expected after the next edge
   task automatic step(input logic r, input logic [DW-1:0] d,
                       input logic eb, input logic ei, input logic er, input string tag);
      item_t it;
      @(posedge clk);
      #1;
      req      = r;
      src_data = d;
      if (!prev_iso) held = d;   // R6: capture only when isolation was low at the edge
      it.at   = cyc + 1;
      it.busy = eb;
      it.iso  = ei;
      it.rst  = er;
      it.rx   = held;
      it.tag  = tag;
      prev_iso = ei;
      q.push_back(it);
   endtask

   task automatic drain();
      while (q.size() > 0) @(negedge clk);
   endtask

   task automatic idle_steps(input int n, input string tag);
      for (int i = 0; i < n; i++) begin
         step(1'b0, DW'($urandom), 1'b0, 1'b0, 1'b0, tag);
      end
   endtask

   // nseq chained sequences; follow-up requests at offset off (1..L) inside each, dup adds one more
   task automatic run_seqs(input int nseq, input int off, input bit dup, input string tag_chain);
      for (int s = 0; s < nseq * L; s++) begin
         logic  r;
         int    p;
         int    k;
         string tg;
         p = s % L;
         k = s / L;
         r = (s == 0);
         for (int kk = 0; kk < nseq - 1; kk++) begin
            if (s == kk * L + off) r = 1'b1;
            if (dup && s == kk * L + off + 1) r = 1'b1;
         end
         if (p < ISO)            tg = (k > 0 && p == 0) ? tag_chain : "R2/R9";
         else if (p < ISO + RST) tg = "R3/R6";
         else                    tg = "R4/R6";
         step(r, DW'($urandom), 1'b1, 1'b1, (p >= ISO && p < ISO + RST), tg);
      end
      step(1'b0, DW'($urandom), 1'b0, 1'b0, 1'b0, "R5/R9");
      idle_steps(2, "R6");
      drain();
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_cmp++;
         n_bad++;
         $display("FAIL watchdog: run hung, got no end expected end");
         $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      // R1: state held in reset
      direct_chk(iso_en === 1'b0 && src_rst === 1'b0 && busy === 1'b0 && rx_data === '0,
                 "R1", $sformatf("%b%b%b/%h", busy, iso_en, src_rst, rx_data), "000/00");
      rst_n = 1'b1;

      // R6: receiver follows data while idle
      idle_steps(5, "R6");
      drain();

      // single sequence
      run_seqs(1, 0, 1'b0, "R7");
      // request during isolation phase chains a second sequence
      run_seqs(2, 1, 1'b0, "R7");
      // request inside the reset phase
      run_seqs(2, ISO + 1, 1'b0, "R7");
      // request on the edge that ends the last settle cycle
      run_seqs(2, L, 1'b0, "R7");
      // duplicate requests collapse into one follow-up
      run_seqs(2, 3, 1'b1, "R8");
      // three chained sequences
      run_seqs(3, 2, 1'b1, "R7/R8");

      // R1: controller reset in the middle of the reset phase
      step(1'b1, DW'($urandom), 1'b1, 1'b1, 1'b0, "R2");
      step(1'b0, DW'($urandom), 1'b1, 1'b1, 1'b0, "R2");
      step(1'b0, DW'($urandom), 1'b1, 1'b1, 1'b1, "R3");
      drain();
      rst_n = 1'b0;
      #1;
      direct_chk(iso_en === 1'b0 && src_rst === 1'b0 && busy === 1'b0 && rx_data === '0,
                 "R1", $sformatf("%b%b%b/%h", busy, iso_en, src_rst, rx_data), "000/00");
      @(negedge clk);
      rst_n    = 1'b1;
      prev_iso = 1'b0;
      held     = '0;
      idle_steps(2, "R1/R6");
      drain();
      run_seqs(1, 0, 1'b0, "R7");

      done = 1'b1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule